// File: doc/BRIEF.md
# Push-Button Burst Writer

This block drives the write port of a FIFO. An operator sets two banks of switches: how many words to send and the value of the first word. Pressing a button then launches one burst. The block writes that many words into the FIFO on consecutive free cycles. Each word is one greater than the word before it, counting modulo 256.

The raw button input is synchronised into the writer's clock domain and then filtered. A new level is accepted only after it has stayed the same for a run of cycles, so contact bounce produces a single trigger. The switches are captured in the cycle the filtered press is recognised, and the burst runs from that captured copy. When the FIFO reports full, the block stops issuing writes and holds its current word until space returns. A press that arrives while a burst is still running is discarded.

The writer runs entirely in its own clock domain. The read side of the FIFO may use an unrelated clock, and the FIFO handles the crossing.

Top module: `burst_writer`

## Requirements
- R1: While reset is asserted and after its release with no press, `wr_en_o` is 0.
- R2: A recognised press with `len_i` = N (1..255) produces exactly N write cycles. The first write enable can appear in the cycle after the press is recognised.
- R3: The first word written equals `start_i` as captured at the press. Each following word equals the previous word plus one.
- R4: The word value wraps from 255 to 0. For example, a start of 254 with a length of 4 yields 254, 255, 0, 1.
- R5: A press recognised while `len_i` is 0 produces no writes.
- R6: Changes on `len_i` or `start_i` after the press is recognised do not change the running burst.
- R7: `wr_en_o` is 0 in every cycle in which `fifo_full_i` is 1. The burst resumes with the held word once `fifo_full_i` returns to 0, so no value is skipped.
- R8: A press recognised while a burst is in progress starts nothing and leaves the running burst unchanged.
- R9: `btn_i` passes through a 2-stage synchroniser. A change of the synchronised level is accepted only after it has differed from the accepted level for DEBOUNCE cycles in a row (default 16). Only an accepted 0-to-1 change counts as a press. Shorter pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Writer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_i | input | 1 | Raw push-button level, active high, asynchronous |
| len_i | input | 8 | Burst length switches (0 = no burst) |
| start_i | input | 8 | First-word switches |
| fifo_full_i | input | 1 | FIFO full flag |
| wr_en_o | output | 1 | FIFO write enable |
| wr_data_o | output | 8 | FIFO write data |

## Verification
The assertions assume that `fifo_full_i` is a level from the writer's own clock domain that is stable around each rising edge. They also assume that the switches are only meaningful in the cycle a press is recognised. The bench therefore changes `fifo_full_i`, the switches and the button just after a rising edge, never at the edge itself. The button is driven freely, with short glitches and bounce trains, because the filter exists to absorb exactly that. Full is asserted in a repeating pattern during long bursts, so that pauses land on first, middle and last words.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int WORD_W = 8;
  localparam int LEN_W  = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LEN_W-1:0]  len_t;

  // value that follows w in a burst (wraps modulo 2**WORD_W)
  function automatic word_t next_word(input word_t w);
    return w + word_t'(1);
  endfunction

  // true when the word about to be written is the final one
  function automatic logic is_last(input len_t remaining);
    return remaining == len_t'(1);
  endfunction

  // a zero length request launches nothing
  function automatic logic is_empty(input len_t n);
    return n == '0;
  endfunction
endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  output logic level_o,
  output logic press_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   level_q;
  logic                   level_d_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], btn_raw};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= '0;
      level_q   <= 1'b0;
      level_d_q <= 1'b0;
    end else begin
      level_d_q <= level_q;
      if (synced != level_q) begin
        if (run_q == CW'(HOLD_CYCLES - 1)) begin
          level_q <= synced;
          run_q   <= '0;
        end else begin
          run_q <= run_q + CW'(1);
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign level_o = level_q;
  assign press_o = level_q & ~level_d_q;
endmodule

// File: rtl/burst_engine.sv
module burst_engine
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trig_i,
  input  len_t  len_i,
  input  word_t first_i,
  input  logic  full_i,
  output logic  wr_en_o,
  output word_t wr_data_o,
  output logic  busy_o,
  output logic  accept_o
);
  logic  busy_q;
  len_t  remain_q;
  word_t data_q;

  assign accept_o  = trig_i && !busy_q && !is_empty(len_i);
  assign wr_en_o   = busy_q && !full_i;
  assign wr_data_o = data_q;
  assign busy_o    = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
      data_q   <= '0;
    end else if (accept_o) begin
      busy_q   <= 1'b1;
      remain_q <= len_i;
      data_q   <= first_i;
    end else if (wr_en_o) begin
      data_q   <= next_word(data_q);
      remain_q <= remain_q - len_t'(1);
      if (is_last(remain_q)) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_writer.sv
module burst_writer
  import burst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEBOUNCE    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        btn_i,
  input  logic [7:0]  len_i,
  input  logic [7:0]  start_i,
  input  logic        fifo_full_i,
  output logic        wr_en_o,
  output logic [7:0]  wr_data_o
);
  // named internal events for the checker
  logic press_w;
  logic level_w;
  logic busy_w;
  logic accept_w;

  btn_debounce #(
    .SYNC_STAGES(SYNC_STAGES),
    .HOLD_CYCLES(DEBOUNCE)
  ) u_deb (
    .clk     (clk),
    .rst_n   (rst_n),
    .btn_raw (btn_i),
    .level_o (level_w),
    .press_o (press_w)
  );

  burst_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (press_w),
    .len_i     (len_i),
    .first_i   (start_i),
    .full_i    (fifo_full_i),
    .wr_en_o   (wr_en_o),
    .wr_data_o (wr_data_o),
    .busy_o    (busy_w),
    .accept_o  (accept_w)
  );
endmodule

// File: rtl/burst_writer_chk.sv
module burst_writer_chk
  import burst_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  fifo_full_i,
  input logic  wr_en_o,
  input word_t wr_data_o,
  input logic  press,
  input logic  busy,
  input len_t  len_i
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy) else $error("reset"); // R1
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) fifo_full_i |-> !wr_en_o); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) busy && fifo_full_i |=> busy && $stable(wr_data_o)); // R7
  AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n) $past(wr_en_o) && busy |-> wr_data_o == word_t'($past(wr_data_o) + 8'd1)); // R3
  AST_DATA_WRAP: assert property (@(posedge clk) disable iff (!rst_n) $past(wr_en_o) && busy && $past(wr_data_o) == 8'hFF |-> wr_data_o == 8'h00); // R4
  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) press && !busy && len_i == '0 |=> !busy); // R5
  AST_PRESS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) press && busy && !wr_en_o |=> busy && $stable(wr_data_o)); // R8
  AST_SINGLE_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n) press |=> !press); // R9
endmodule

bind burst_writer burst_writer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_full_i (fifo_full_i),
  .wr_en_o     (wr_en_o),
  .wr_data_o   (wr_data_o),
  .press       (press_w),
  .busy        (busy_w),
  .len_i       (len_i)
);

// File: tb/sim_burst_writer.sv
`timescale 1ns/1ps
module sim_burst_writer;
  localparam int DEB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn_i = 1'b0;
  logic [7:0] len_i = '0;
  logic [7:0] start_i = '0;
  logic       fifo_full_i = 1'b0;
  logic       wr_en_o;
  logic [7:0] wr_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_en = 1'b0;
  bit finished = 1'b0;
  int seen[$];

  always #2 clk = ~clk;

  burst_writer #(.DEBOUNCE(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .len_i(len_i),
    .start_i(start_i), .fifo_full_i(fifo_full_i),
    .wr_en_o(wr_en_o), .wr_data_o(wr_data_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // full pattern driven just after each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 fifo_full_i <= stall_en && (cyc % 3 == 1);
  end

  // behavioural reference model, evaluated between edges
  int  m_hist0, m_hist1, m_level, m_prev, m_run;
  bit  m_busy;
  int  m_left, m_word;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_hist0 = 0; m_hist1 = 0; m_level = 0; m_prev = 0; m_run = 0;
      m_busy = 0; m_left = 0; m_word = 0;
    end else begin
      bit exp_en;
      bit trig;
      exp_en = m_busy && !fifo_full_i;
      check(wr_en_o == exp_en, "R7", int'(wr_en_o), int'(exp_en));
      if (exp_en) check(int'(wr_data_o) == m_word, "R3", int'(wr_data_o), m_word);
      if (wr_en_o) seen.push_back(int'(wr_data_o));
      // advance model to the coming edge
      trig = (m_level == 1) && (m_prev == 0);
      m_prev = m_level;
      if (m_hist1 != m_level) begin
        m_run++;
        if (m_run == DEB) begin m_level = m_hist1; m_run = 0; end
      end else m_run = 0;
      m_hist1 = m_hist0;
      m_hist0 = int'(btn_i);
      if (m_busy) begin
        if (!fifo_full_i) begin
          m_word = (m_word + 1) % 256;
          m_left--;
          if (m_left == 0) m_busy = 0;
        end
      end else if (trig && len_i != 0) begin
        m_busy = 1; m_left = int'(len_i); m_word = int'(start_i);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input int hold);
    btn_i = 1'b1; step(hold);
    btn_i = 1'b0; step(DEB + 6);
  endtask

  task automatic expect_burst(input string req, input int n, input int first);
    check(seen.size() == n, req, seen.size(), n);
    for (int i = 0; i < seen.size() && i < n; i++)
      check(seen[i] == (first + i) % 256, req, seen[i], (first + i) % 256);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(5);
    check(wr_en_o == 1'b0, "R1", int'(wr_en_o), 0);
    rst_n = 1'b1;
    step(30);
    check(seen.size() == 0, "R1", seen.size(), 0);

    // plain burst
    seen.delete(); len_i = 8'd5; start_i = 8'd10;
    push(DEB + 6); step(60);
    expect_burst("R2", 5, 10);

    // wrap across 255
    seen.delete(); len_i = 8'd4; start_i = 8'd254;
    push(DEB + 6); step(60);
    expect_burst("R4", 4, 254);

    // zero length
    seen.delete(); len_i = 8'd0; start_i = 8'd33;
    push(DEB + 6); step(60);
    check(seen.size() == 0, "R5", seen.size(), 0);

    // stalls and switch changes mid burst
    seen.delete(); len_i = 8'd20; start_i = 8'd100; stall_en = 1'b1;
    btn_i = 1'b1; step(DEB + 6);
    len_i = 8'd3; start_i = 8'd7;
    btn_i = 1'b0; step(DEB + 6); step(80);
    expect_burst("R6", 20, 100);

    // press during a running burst
    seen.delete(); len_i = 8'd60; start_i = 8'd0;
    push(DEB + 6);
    len_i = 8'd3; start_i = 8'd200;
    push(DEB + 6);
    step(150);
    expect_burst("R8", 60, 0);
    stall_en = 1'b0; step(4);

    // short glitches are filtered
    seen.delete(); len_i = 8'd2; start_i = 8'd50;
    for (int g = 0; g < 4; g++) begin
      btn_i = 1'b1; step(DEB / 2);
      btn_i = 1'b0; step(DEB / 2);
    end
    step(DEB + 10);
    check(seen.size() == 0, "R9", seen.size(), 0);

    // bounce train then a firm press gives one burst
    seen.delete();
    for (int g = 0; g < 3; g++) begin
      btn_i = 1'b1; step(3);
      btn_i = 1'b0; step(2);
    end
    push(DEB + 8); step(40);
    expect_burst("R9", 2, 50);

    // longest burst
    seen.delete(); len_i = 8'd255; start_i = 8'd0;
    push(DEB + 6); step(300);
    expect_burst("R2", 255, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule